// File: doc/BRIEF.md
# Byte-Select External Memory Write Controller

This block drives byte writes onto a 16-bit multiplexed address/data bus that serves word-wide flash and SRAM devices. A one-cycle start request carries a 21-bit byte pointer, one data byte and a target flag that says whether the write goes to a flash or an SRAM device. The block then runs a fixed cycle of four clocks. In the first two clocks the word address is on the bus, and an address-latch strobe lets external latches capture it. In the last two clocks the data byte is on the bus and the high write strobe pulses once.

The data byte is copied onto both halves of the bus, so any byte lane can take it. Bit 0 of the pointer picks the lane that is written. A flash target receives this bit on a byte-address line. An SRAM target receives it as a pair of upper and lower lane enables. A held mode output drives the byte/word select pin of a flash device.

Top module: `bswTop`

## Requirements
- R1: A start is accepted only in a cycle where `busy` is low. `busy` is high for exactly four cycles, starting in the cycle after an accepted start. A start while `busy` is high does not change the running cycle.
- R2: In busy cycle 1, `ale` is 1. In busy cycles 1 and 2, `ad` equals pointer bits [16:1] and `addrUp` equals pointer bits [20:17]. In busy cycle 2, `ale` is 0.
- R3: In busy cycle 3, `wrhN` is 0. In busy cycle 4, `wrhN` is 1. In both cycles, `ad[15:8]` and `ad[7:0]` each equal the data byte and `addrUp` still holds pointer bits [20:17].
- R4: `wrlN` and `oeN` are 1 in every cycle. `ale` is 1 only in busy cycle 1, and `wrhN` is 0 only in busy cycle 3.
- R5: Flash target (`tgtSram`=0): `ba0` equals pointer bit 0 in all four busy cycles, and `ubN` and `lbN` stay 1.
- R6: SRAM target (`tgtSram`=1): `ba0` is 0. In busy cycles 3 and 4, pointer bit 0 = 0 gives `lbN`=0 and `ubN`=1, and bit 0 = 1 gives `ubN`=0 and `lbN`=1. In every other cycle both enables are 1.
- R7: `wordModeN` is 1 after reset. Each accepted start loads it with 0 for a flash target and 1 for an SRAM target, and it holds that value until the next accepted start.
- R8: `done` is 1 for exactly one cycle, the cycle after busy cycle 4. A start in that cycle is accepted.
- R9: After reset, `busy`, `done` and `ale` are 0, `wrhN`, `ubN` and `lbN` are 1, and `ad`, `addrUp` and `ba0` are 0. Outside busy cycles, `ad`, `addrUp` and `ba0` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Write request, sampled while idle |
| ptr | input | 21 | Byte pointer |
| wrData | input | 8 | Byte to write |
| tgtSram | input | 1 | 1 = SRAM target, 0 = flash target |
| ad | output | 16 | Multiplexed address/data bus |
| addrUp | output | 4 | Upper word address lines |
| ale | output | 1 | Address latch enable, active high |
| wrhN | output | 1 | High-byte write strobe, active low |
| wrlN | output | 1 | Low-byte write strobe, active low, never asserted |
| oeN | output | 1 | Output enable, active low, never asserted |
| ba0 | output | 1 | Byte address for flash targets |
| ubN | output | 1 | Upper lane enable, active low |
| lbN | output | 1 | Lower lane enable, active low |
| wordModeN | output | 1 | Flash byte/word select, 0 = byte mode |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse of one write can fall in the same cycle as the acceptance of the next start. The bench provokes this with back-to-back writes, in which it raises `start` in the cycle where `done` is high. It then checks that `done` lasts exactly one cycle, that the next cycle opens with `ale` high and the new address on the bus, and that `wordModeN` switches to the new target. A start raised while `busy` is high, carrying a different pointer, byte and target, is judged at the bus outputs, which must keep the values latched for the cycle already running.

// File: rtl/bswPkg.sv
package bswPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_AHOLD,
    PH_WRITE,
    PH_DHOLD
  } phase_t;

  typedef struct packed {
    logic load;
    logic aleOn;
    logic addrOn;
    logic dataOn;
    logic wrOn;
    logic laneOn;
  } strobe_t;
endpackage

// File: rtl/bswCtrl.sv
module bswCtrl
  import bswPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  phase_t phase, phaseNext;
  logic   doneQ;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (start) phaseNext = PH_ADDR;
      PH_ADDR:  phaseNext = PH_AHOLD;
      PH_AHOLD: phaseNext = PH_WRITE;
      PH_WRITE: phaseNext = PH_DHOLD;
      PH_DHOLD: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= (phase == PH_DHOLD);
    end
  end

  always_comb begin
    stb        = '0;
    stb.load   = start && (phase == PH_IDLE);
    stb.aleOn  = (phase == PH_ADDR);
    stb.addrOn = (phase == PH_ADDR) || (phase == PH_AHOLD);
    stb.dataOn = (phase == PH_WRITE) || (phase == PH_DHOLD);
    stb.wrOn   = (phase == PH_WRITE);
    stb.laneOn = stb.dataOn;
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;
endmodule

// File: rtl/bswDatapath.sv
module bswDatapath
  import bswPkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [PTR_W-1:0]              ptr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          tgtSram,
  output logic [2*DATA_W-1:0]           ad,
  output logic [PTR_W-2*DATA_W-2:0]     addrUp,
  output logic                          ale,
  output logic                          wrhN,
  output logic                          ba0,
  output logic                          ubN,
  output logic                          lbN,
  output logic                          wordModeN
);
  localparam int BUS_W = 2 * DATA_W;
  localparam int UP_W  = PTR_W - BUS_W - 1;

  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] dataQ;
  logic              sramQ;
  logic              wordModeQ;
  logic              laneHi;
  logic              addrValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ      <= '0;
      dataQ     <= '0;
      sramQ     <= 1'b0;
      wordModeQ <= 1'b1;
    end else if (stb.load) begin
      ptrQ      <= ptr;
      dataQ     <= wrData;
      sramQ     <= tgtSram;
      wordModeQ <= tgtSram;
    end
  end

  assign laneHi    = ptrQ[0];
  assign addrValid = stb.addrOn || stb.dataOn;

  always_comb begin
    if (stb.addrOn)      ad = ptrQ[BUS_W:1];
    else if (stb.dataOn) ad = {2{dataQ}};
    else                 ad = '0;
  end

  assign addrUp    = addrValid ? ptrQ[PTR_W-1:PTR_W-UP_W] : '0;
  assign ale       = stb.aleOn;
  assign wrhN      = !stb.wrOn;
  assign ba0       = addrValid && !sramQ && laneHi;
  assign ubN       = !(stb.laneOn && sramQ && laneHi);
  assign lbN       = !(stb.laneOn && sramQ && !laneHi);
  assign wordModeN = wordModeQ;
endmodule

// File: rtl/bswTop.sv
module bswTop
  import bswPkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      tgtSram,
  output logic [2*DATA_W-1:0]       ad,
  output logic [PTR_W-2*DATA_W-2:0] addrUp,
  output logic                      ale,
  output logic                      wrhN,
  output logic                      wrlN,
  output logic                      oeN,
  output logic                      ba0,
  output logic                      ubN,
  output logic                      lbN,
  output logic                      wordModeN,
  output logic                      busy,
  output logic                      done
);
  localparam int BUS_W = 2 * DATA_W;
  localparam int UP_W  = PTR_W - BUS_W - 1;

  strobe_t stb;

  bswCtrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stb  (stb),
    .busy (busy),
    .done (done)
  );

  bswDatapath #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .ptr      (ptr),
    .wrData   (wrData),
    .tgtSram  (tgtSram),
    .ad       (ad),
    .addrUp   (addrUp),
    .ale      (ale),
    .wrhN     (wrhN),
    .ba0      (ba0),
    .ubN      (ubN),
    .lbN      (lbN),
    .wordModeN(wordModeN)
  );

  assign wrlN = 1'b1;
  assign oeN  = 1'b1;
endmodule

// File: rtl/bswChecker.sv
module bswChecker #(
  parameter int BUS_W = 16,
  parameter int UP_W  = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] ad,
  input logic [UP_W-1:0]  addrUp,
  input logic             ale,
  input logic             wrhN,
  input logic             ubN,
  input logic             lbN,
  input logic             ba0,
  input logic             busy,
  input logic             done
);
  AST_DATA_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    !wrhN |-> (ad[BUS_W-1:BUS_W/2] == ad[BUS_W/2-1:0])); // R3
  AST_WRITE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrhN) |-> $past(ale, 2)); // R4
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |=> !ale); // R2
  AST_LANE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!ubN, !lbN})); // R6
  AST_LANE_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!ubN || !lbN) |-> (busy && !ale)); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R8
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(addrUp) && $stable(ba0))); // R1
  AST_BUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ad == '0 && addrUp == '0 && !ba0)); // R9
endmodule

bind bswTop bswChecker #(.BUS_W(BUS_W), .UP_W(UP_W)) u_chk (.*);

// File: tb/sim_bswTop.sv
module sim_bswTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [20:0] ptr = '0;
  logic [7:0]  wrData = '0;
  logic        tgtSram = 1'b0;
  logic [15:0] ad;
  logic [3:0]  addrUp;
  logic        ale, wrhN, wrlN, oeN, ba0, ubN, lbN, wordModeN, busy, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bswTop u0 (.*);

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expAd(int ph, logic [20:0] p, logic [7:0] d);
    return (ph < 2) ? p[16:1] : {d, d};
  endfunction

  function automatic logic [1:0] expLanes(int ph, logic [20:0] p, logic s);
    if (ph < 2 || !s) return 2'b11;
    return p[0] ? 2'b01 : 2'b10;
  endfunction

  // Entered on a negedge; leaves on the negedge of the done cycle.
  task automatic doWrite(logic [20:0] p, logic [7:0] d, logic s, bit poke);
    ptr = p; wrData = d; tgtSram = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int ph = 0; ph < 4; ph++) begin
      chk("R1", "busy", busy, 1);
      chk("R2", "ale", ale, (ph == 0));
      chk("R3", "wrhN", wrhN, (ph != 2));
      chk(ph < 2 ? "R2" : "R3", "ad", ad, expAd(ph, p, d));
      chk("R2", "addrUp", addrUp, p[20:17]);
      chk("R4", "wrlN/oeN", {wrlN, oeN}, 2'b11);
      chk(s ? "R6" : "R5", "ba0", ba0, s ? 1'b0 : p[0]);
      chk(s ? "R6" : "R5", "ubN/lbN", {ubN, lbN}, expLanes(ph, p, s));
      chk("R7", "wordModeN", wordModeN, s);
      chk("R8", "done low", done, 0);
      if (poke && ph == 0) begin
        ptr = ~p; wrData = ~d; tgtSram = ~s; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8", "done", done, 1);
    chk("R1", "busy end", busy, 0);
    chk("R9", "ad idle", ad, 0);
    chk("R7", "wordModeN hold", wordModeN, s);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    chk("R8", "done single", done, 0);
    chk("R1", "stay idle", busy, 0);
    chk("R4", "ale idle", ale, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R9", "busy rst", busy, 0);
    chk("R9", "done rst", done, 0);
    chk("R9", "strobes rst", {ale, wrhN, ubN, lbN}, 4'b0111);
    chk("R9", "bus rst", {ad, addrUp, ba0}, 0);
    chk("R7", "wordModeN rst", wordModeN, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "idle after rst", busy, 0);

    doWrite(21'h0ABCDE, 8'h5A, 1'b0, 0); idleCheck();
    doWrite(21'h0ABCDF, 8'hA5, 1'b0, 0); idleCheck();
    doWrite(21'h123456, 8'h3C, 1'b1, 0); idleCheck();
    doWrite(21'h123457, 8'hC3, 1'b1, 0); idleCheck();
    doWrite(21'h1FFFFF, 8'hFF, 1'b1, 1); idleCheck();
    doWrite(21'h000000, 8'h00, 1'b0, 1); idleCheck();
    // back-to-back: start raised in the done cycle (R8)
    doWrite(21'h1F0F0F, 8'h81, 1'b0, 0);
    doWrite(21'h0F0F0E, 8'h7E, 1'b1, 0);
    doWrite(21'h155555, 8'h11, 1'b0, 1);
    idleCheck();

    for (int i = 0; i < 60; i++) begin
      logic [20:0] rp;
      logic [7:0]  rd;
      logic        rs;
      bit          pk;
      int          gap;
      rp  = 21'($urandom);
      rd  = 8'($urandom);
      rs  = 1'($urandom);
      pk  = 1'($urandom);
      gap = $urandom_range(0, 2);
      doWrite(rp, rd, rs, pk);
      for (int g = 0; g < gap; g++) idleCheck();
    end
    idleCheck();
    summary();
  end
endmodule